// File: doc/BRIEF.md
# Loopback CRC and Address Status Unit

This unit sits on the looped-back path of a half-duplex Ethernet controller running a self-test. The frame source supplies bytes with start and end strobes. In generate mode the unit appends a four-byte CRC-32 to the frame. In pass-through mode the frame is forwarded unchanged, and its last four bytes are taken as a CRC that software supplied. The outgoing stream is turned back into the receive side, which compares the destination address against a six-byte station address, checks the CRC and produces a one-byte receive status.

The transmitter and the receiver share one CRC-32 register, so it can either generate or check, never both. In generate mode the receiver therefore always reports a CRC error. That error is reported only when the frame's address passes the filter. A rejected frame, or a frame that arrives with a good CRC, reports "received intact" only. A self-test uses this to confirm the address filter: a frame that should carry an error but shows none was rejected on its address.

Top module: `lbk_loopback_status`

## Requirements
- R1: After reset, `lp_valid` is 0, `rx_status` is 00h and `rx_err` is 0.
- R2: With inhibit clear, each accepted byte appears on the looped stream one clock later. The four bytes of the complemented CRC-32 follow on the next four clocks, with no gap. The CRC uses polynomial 04C11DB7h, bit-reflected, with an all-ones seed, and is sent least significant byte first. `lp_eof` is set on the fourth CRC byte only.
- R3: With inhibit set, the looped stream carries exactly the supplied bytes, with `lp_eof` on the last supplied byte and nothing appended.
- R4: Input beats presented while the CRC is being appended are dropped, including any start strobe, and do not change the looped stream or the status.
- R5: With inhibit clear and the address accepted, the frame reports status 02h (bit1 = CRC error) and pulses `rx_err`.
- R6: With inhibit set, the receiver runs the shared CRC register over every looped byte. A residue of C704DD7Bh (MSB-first form) gives status 01h (bit0 = received intact). Any other residue, with the address accepted, gives 02h and pulses `rx_err`.
- R7: A frame whose address is not accepted reports 01h and does not pulse `rx_err`, whatever its CRC.
- R8: With promiscuous mode on, every destination address is accepted.
- R9: Looped byte k (k = 0 is the first byte) is compared with `station_addr[8k+7:8k]`, for k = 0 to 5. A frame with fewer than six looped bytes never matches.
- R10: The status is loaded on the clock after the looped end byte and is held until the next looped end byte. `rx_err` is high for that one clock only.
- R11: Inhibit and promiscuous are sampled with the start byte and held for the rest of the frame. A byte with `in_valid` but no start strobe, arriving outside a frame, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last supplied byte of frame |
| in_data | input | 8 | Input byte |
| inhibit_crc | input | 1 | 1: pass-through and check; 0: generate and append |
| promisc | input | 1 | Accept any destination address |
| station_addr | input | 48 | Station address, byte k at bits 8k+7:8k |
| lp_valid | output | 1 | Looped byte valid |
| lp_sof | output | 1 | Looped first byte |
| lp_eof | output | 1 | Looped last byte |
| lp_data | output | 8 | Looped byte |
| rx_status | output | 8 | Receive status: bit0 intact, bit1 CRC error |
| rx_err | output | 1 | One-clock error pulse at status load |

## Verification
The bench attacks how the shared CRC register is handed over between generation and checking. If inhibit were sampled late, the CRC bytes would go missing or be added to a pass-through frame. If the register were not held during the append, the CRC bytes on the wire would be wrong. The bench also targets address gating of errors: a design that gated errors wrongly would flag non-matching frames, or miss the forced error on matching ones. Frames with reversed address bytes, frames shorter than the address and start strobes sent during the append check byte order, the length rule and dropped input.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  localparam int unsigned OCTET_W   = 8;
  localparam int unsigned FCS_W     = 32;
  localparam int unsigned FCS_BYTES = FCS_W / OCTET_W;

  // reflected form of 04C11DB7h, seed all ones
  localparam logic [FCS_W-1:0] FCS_POLY_RX   = 32'hEDB88320;
  localparam logic [FCS_W-1:0] FCS_SEED      = 32'hFFFFFFFF;
  // good-frame residue written MSB first
  localparam logic [FCS_W-1:0] FCS_MAGIC_MSB = 32'hC704DD7B;

  localparam logic [OCTET_W-1:0] RXS_INTACT  = 8'h01;
  localparam logic [OCTET_W-1:0] RXS_FCS_BAD = 8'h02;

  typedef struct packed {
    logic               vld;
    logic               sof;
    logic               eof;
    logic               inh;
    logic               prm;
    logic [OCTET_W-1:0] dat;
  } lbk_beat_t;

  function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c,
                                                input logic [OCTET_W-1:0] d);
    logic [FCS_W-1:0] r;
    r = c;
    for (int i = 0; i < OCTET_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ FCS_POLY_RX;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [FCS_W-1:0] mirror_fcs(input logic [FCS_W-1:0] v);
    logic [FCS_W-1:0] r;
    for (int i = 0; i < FCS_W; i++) r[i] = v[FCS_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/lbk_fcs_engine.sv
module lbk_fcs_engine
  import lbk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seed_i,
  input  logic               step_i,
  input  logic               last_i,
  input  logic [OCTET_W-1:0] dat_i,
  output logic [FCS_W-1:0]   fcs_o,
  output logic               magic_ok_o
);

  localparam logic [FCS_W-1:0] MAGIC_REG = mirror_fcs(FCS_MAGIC_MSB);

  logic [FCS_W-1:0] fcs_q, fcs_d, base;
  logic             ok_q, ok_d, ok_en;

  always_comb begin
    base  = seed_i ? FCS_SEED : fcs_q;
    fcs_d = fcs_step(base, dat_i);
    ok_en = step_i & last_i;
    ok_d  = (fcs_d == MAGIC_REG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fcs_q <= FCS_SEED;
    else if (step_i) fcs_q <= fcs_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ok_q <= 1'b0;
    else if (ok_en) ok_q <= ok_d;
  end

  assign fcs_o      = fcs_q;
  assign magic_ok_o = ok_q;

endmodule

// File: rtl/lbk_tx_framer.sv
module lbk_tx_framer
  import lbk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid_i,
  input  logic               in_sof_i,
  input  logic               in_eof_i,
  input  logic [OCTET_W-1:0] in_data_i,
  input  logic               inhibit_i,
  input  logic               promisc_i,
  input  logic [FCS_W-1:0]   fcs_i,
  output logic               seed_o,
  output logic               step_o,
  output logic               last_o,
  output logic [OCTET_W-1:0] step_dat_o,
  output lbk_beat_t          beat_o
);

  localparam int unsigned  AIW      = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
  localparam logic [AIW-1:0] APP_LAST = AIW'(FCS_BYTES - 1);

  lbk_beat_t      beat_q, beat_d;
  logic           open_q, open_d;
  logic           inh_q, inh_d;
  logic           prm_q, prm_d;
  logic           app_q, app_d;
  logic [AIW-1:0] idx_q, idx_d;
  logic           accept, fr_inh, fr_prm;

  always_comb begin
    accept = in_valid_i & ~app_q & (in_sof_i | open_q);
    fr_inh = in_sof_i ? inhibit_i : inh_q;
    fr_prm = in_sof_i ? promisc_i : prm_q;

    beat_d = '0;
    open_d = open_q;
    inh_d  = inh_q;
    prm_d  = prm_q;
    app_d  = app_q;
    idx_d  = idx_q;

    if (app_q) begin
      beat_d.vld = 1'b1;
      beat_d.dat = ~fcs_i[idx_q*OCTET_W +: OCTET_W];
      beat_d.eof = (idx_q == APP_LAST);
      beat_d.inh = inh_q;
      beat_d.prm = prm_q;
      idx_d      = idx_q + AIW'(1);
      if (idx_q == APP_LAST) app_d = 1'b0;
    end else if (accept) begin
      beat_d.vld = 1'b1;
      beat_d.sof = in_sof_i;
      beat_d.eof = in_eof_i & fr_inh;
      beat_d.inh = fr_inh;
      beat_d.prm = fr_prm;
      beat_d.dat = in_data_i;
      open_d     = ~in_eof_i;
      inh_d      = fr_inh;
      prm_d      = fr_prm;
      if (in_eof_i && !fr_inh) begin
        app_d = 1'b1;
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      open_q <= 1'b0;
      inh_q  <= 1'b0;
      prm_q  <= 1'b0;
      app_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      beat_q <= beat_d;
      open_q <= open_d;
      inh_q  <= inh_d;
      prm_q  <= prm_d;
      app_q  <= app_d;
      idx_q  <= idx_d;
    end
  end

  assign seed_o     = accept & in_sof_i;
  assign step_o     = accept;
  assign last_o     = in_eof_i;
  assign step_dat_o = in_data_i;
  assign beat_o     = beat_q;

  // R2: the appended CRC bytes run back to back
  a_r2_append_run: assert property (@(posedge clk) disable iff (!rst_n)
    (app_q && idx_q != APP_LAST) |=> (beat_q.vld && !beat_q.eof));

  // R3: a pass-through frame never enters the append phase
  a_r3_no_tail_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_eof_i && fr_inh) |=> !app_q);

  // R4: a start strobe during the append never reaches the looped stream
  a_r4_drop_during_append: assert property (@(posedge clk) disable iff (!rst_n)
    app_q |=> !beat_q.sof);

endmodule

// File: rtl/lbk_rx_check.sv
module lbk_rx_check
  import lbk_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  lbk_beat_t                     beat_i,
  input  logic                          magic_ok_i,
  input  logic [ADDR_BYTES*OCTET_W-1:0] station_i,
  output logic [OCTET_W-1:0]            status_o,
  output logic                          err_o
);

  localparam int unsigned     CW   = $clog2(ADDR_BYTES + 1);
  localparam int unsigned     HW   = 2 ** CW;
  localparam logic [CW-1:0]   FULL = CW'(ADDR_BYTES);

  logic [HW-1:0]      hit;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic               match_q, match_d;
  logic [OCTET_W-1:0] status_q, status_d;
  logic               err_q, err_d;
  logic               addr_ok, fcs_bad, flag, close;

  for (genvar k = 0; k < HW; k++) begin : g_cmp
    if (k < ADDR_BYTES) begin : g_live
      assign hit[k] = (beat_i.dat == station_i[k*OCTET_W +: OCTET_W]);
    end else begin : g_pad
      assign hit[k] = 1'b0;
    end
  end

  always_comb begin
    cnt_d   = cnt_q;
    match_d = match_q;
    if (beat_i.vld) begin
      if (beat_i.sof) begin
        cnt_d   = CW'(1);
        match_d = hit[0];
      end else if (cnt_q < FULL) begin
        cnt_d   = cnt_q + CW'(1);
        match_d = match_q & hit[cnt_q];
      end
    end
    addr_ok  = beat_i.prm | (match_d & (cnt_d == FULL));
    fcs_bad  = ~beat_i.inh | ~magic_ok_i;
    flag     = addr_ok & fcs_bad;
    close    = beat_i.vld & beat_i.eof;
    status_d = flag ? RXS_FCS_BAD : RXS_INTACT;
    err_d    = close & flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else if (beat_i.vld) begin
      cnt_q   <= cnt_d;
      match_q <= match_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_q <= '0;
    else if (close) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign status_o = status_q;
  assign err_o    = err_q;

  // R10: status only moves after a looped end byte
  a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_i.vld && beat_i.eof) |=> $stable(status_o));

  // R10: the pulse always goes with an error status
  a_r10_err_with_status: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (status_o == RXS_FCS_BAD));

  // R7: rejected frames stay silent
  a_r7_quiet_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i.vld && beat_i.eof && !addr_ok) |=> (!err_o && status_o == RXS_INTACT));

  // R5: generate mode forces the error on accepted frames
  a_r5_forced_error: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i.vld && beat_i.eof && !beat_i.inh && addr_ok) |=> (err_o && status_o == RXS_FCS_BAD));

endmodule

// File: rtl/lbk_loopback_status.sv
module lbk_loopback_status
  import lbk_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_sof,
  input  logic                          in_eof,
  input  logic [OCTET_W-1:0]            in_data,
  input  logic                          inhibit_crc,
  input  logic                          promisc,
  input  logic [ADDR_BYTES*OCTET_W-1:0] station_addr,
  output logic                          lp_valid,
  output logic                          lp_sof,
  output logic                          lp_eof,
  output logic [OCTET_W-1:0]            lp_data,
  output logic [OCTET_W-1:0]            rx_status,
  output logic                          rx_err
);

  logic               seed, step, last, magic_ok;
  logic [OCTET_W-1:0] step_dat;
  logic [FCS_W-1:0]   fcs;
  lbk_beat_t          beat;

  lbk_tx_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (in_valid),
    .in_sof_i   (in_sof),
    .in_eof_i   (in_eof),
    .in_data_i  (in_data),
    .inhibit_i  (inhibit_crc),
    .promisc_i  (promisc),
    .fcs_i      (fcs),
    .seed_o     (seed),
    .step_o     (step),
    .last_o     (last),
    .step_dat_o (step_dat),
    .beat_o     (beat)
  );

  lbk_fcs_engine u_fcs (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_i     (seed),
    .step_i     (step),
    .last_i     (last),
    .dat_i      (step_dat),
    .fcs_o      (fcs),
    .magic_ok_o (magic_ok)
  );

  lbk_rx_check #(.ADDR_BYTES(ADDR_BYTES)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_i     (beat),
    .magic_ok_i (magic_ok),
    .station_i  (station_addr),
    .status_o   (rx_status),
    .err_o      (rx_err)
  );

  assign lp_valid = beat.vld;
  assign lp_sof   = beat.sof;
  assign lp_eof   = beat.eof;
  assign lp_data  = beat.dat;

endmodule

// File: tb/test_lbk_loopback_status.sv
module test_lbk_loopback_status;

  typedef logic [7:0] bq_t[$];

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        inhibit_crc, promisc;
  logic [47:0] station_addr;
  logic        lp_valid, lp_sof, lp_eof;
  logic [7:0]  lp_data, rx_status;
  logic        rx_err;

  int checks = 0;
  int failures = 0;
  int cap_len = 0;
  int err_seen = 0;
  bit finished = 1'b0;

  // reference model state
  bit        m_v, m_sof, m_eof, m_inh, m_prm, m_open, m_finh, m_fprm, m_err;
  logic [7:0] m_d, m_status;
  bq_t       txq, rxq, appq;

  always #5 clk = ~clk;

  lbk_loopback_status i_lbk_loopback_status (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .inhibit_crc(inhibit_crc), .promisc(promisc),
    .station_addr(station_addr), .lp_valid(lp_valid), .lp_sof(lp_sof), .lp_eof(lp_eof),
    .lp_data(lp_data), .rx_status(rx_status), .rx_err(rx_err)
  );

  function automatic logic [31:0] fcs_of(bq_t q);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < q.size(); i++)
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ q[i][b]) c = (c >> 1) ^ 32'hEDB88320;
        else                c = c >> 1;
      end
    return ~c;
  endfunction

  function automatic bit fcs_good(bq_t q);
    bq_t body;
    logic [31:0] f;
    int n;
    n = q.size();
    if (n < 4) return 1'b0;
    for (int i = 0; i < n - 4; i++) body.push_back(q[i]);
    f = fcs_of(body);
    return {q[n-1], q[n-2], q[n-3], q[n-4]} == f;
  endfunction

  function automatic bit addr_hit(bq_t q);
    if (q.size() < 6) return 1'b0;
    for (int k = 0; k < 6; k++)
      if (q[k] != station_addr[k*8 +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bq_t with_fcs(bq_t q);
    bq_t r;
    logic [31:0] f;
    r = q;
    f = fcs_of(q);
    for (int b = 0; b < 4; b++) r.push_back(f[b*8 +: 8]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // cycle model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_v = 0; m_sof = 0; m_eof = 0; m_inh = 0; m_prm = 0; m_open = 0;
      m_finh = 0; m_fprm = 0; m_err = 0; m_d = '0; m_status = '0;
      txq.delete(); rxq.delete(); appq.delete();
    end else begin
      m_err = 0;
      if (m_v) begin
        if (m_sof) rxq.delete();
        rxq.push_back(m_d);
        if (m_eof) begin
          bit acc, bad;
          acc = m_prm || addr_hit(rxq);
          bad = !m_inh || !fcs_good(rxq);
          m_err = acc && bad;
          m_status = m_err ? 8'h02 : 8'h01;
        end
      end
      if (appq.size() != 0) begin
        m_d = appq.pop_front();
        m_v = 1; m_sof = 0; m_eof = (appq.size() == 0); m_inh = m_finh; m_prm = m_fprm;
      end else if (in_valid && (in_sof || m_open)) begin
        if (in_sof) begin
          txq.delete();
          m_finh = inhibit_crc;
          m_fprm = promisc;
        end
        txq.push_back(in_data);
        m_v = 1; m_d = in_data; m_sof = in_sof; m_eof = in_eof && m_finh;
        m_inh = m_finh; m_prm = m_fprm; m_open = !in_eof;
        if (in_eof && !m_finh) begin
          logic [31:0] f;
          f = fcs_of(txq);
          for (int b = 0; b < 4; b++) appq.push_back(f[b*8 +: 8]);
        end
      end else begin
        m_v = 0; m_sof = 0; m_eof = 0;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (lp_valid) cap_len++;
      if (rx_err) err_seen++;
      chk(lp_valid === m_v, "R2/R3", "lp_valid", 32'(lp_valid), 32'(m_v));
      if (m_v) begin
        chk(lp_data === m_d, "R2/R3", "lp_data", 32'(lp_data), 32'(m_d));
        chk(lp_sof === m_sof, "R11", "lp_sof", 32'(lp_sof), 32'(m_sof));
        chk(lp_eof === m_eof, "R2/R3", "lp_eof", 32'(lp_eof), 32'(m_eof));
      end
      chk(rx_status === m_status, "R10", "rx_status", 32'(rx_status), 32'(m_status));
      chk(rx_err === m_err, "R10", "rx_err", 32'(rx_err), 32'(m_err));
    end
  end

  task automatic send(bq_t q, bit inh, bit prm, bit flip, int junk);
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = (i == q.size() - 1);
      in_data = q[i];
      inhibit_crc = (i == 0 || !flip) ? inh : !inh;
      promisc = (i == 0 || !flip) ? prm : !prm;
    end
    for (int j = 0; j < junk; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b1; in_eof = (j == junk - 1);
      in_data = 8'hA5; inhibit_crc = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic frame_case(bq_t q, bit inh, bit prm, bit flip, int junk,
                            logic [7:0] exp_st, int exp_err, int exp_len, string req);
    int e0;
    cap_len = 0;
    e0 = err_seen;
    send(q, inh, prm, flip, junk);
    repeat (8) @(negedge clk);
    chk(rx_status == exp_st, req, "status", 32'(rx_status), 32'(exp_st));
    chk((err_seen - e0) == exp_err, req, "err pulses", err_seen - e0, exp_err);
    chk(cap_len == exp_len, req, "looped length", cap_len, exp_len);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog all requirements actual=hung expected=finish");
      summary();
    end
  end

  initial begin
    bq_t fm, fo, fr, fs, g, b;
    rst_n = 1'b0; in_valid = 0; in_sof = 0; in_eof = 0; in_data = '0;
    inhibit_crc = 0; promisc = 0; station_addr = 48'h060504030201;
    fm = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h10, 8'h11, 8'h12, 8'h13};
    fo = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h07, 8'h20, 8'h21};
    fr = '{8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01, 8'h30, 8'h31};
    fs = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lp_valid == 1'b0, "R1", "reset lp_valid", 32'(lp_valid), 0);
    chk(rx_status == 8'h00, "R1", "reset status", 32'(rx_status), 0);
    chk(rx_err == 1'b0, "R1", "reset err", 32'(rx_err), 0);

    // R5 / R2: generate mode, matching address
    frame_case(fm, 0, 0, 0, 0, 8'h02, 1, 14, "R5");
    // R7: generate mode, foreign address
    frame_case(fo, 0, 0, 0, 0, 8'h01, 0, 12, "R7");
    // R8: promiscuous accepts the foreign address
    frame_case(fo, 0, 1, 0, 0, 8'h02, 1, 12, "R8");
    // R6 / R3: pass-through with good software CRC
    g = with_fcs(fm);
    frame_case(g, 1, 0, 0, 0, 8'h01, 0, 14, "R6");
    // R6: corrupted software CRC
    b = g;
    b[b.size()-1] = b[b.size()-1] ^ 8'h01;
    frame_case(b, 1, 0, 0, 0, 8'h02, 1, 14, "R6");
    // R7: bad CRC on a rejected frame stays quiet
    b = with_fcs(fo);
    b[0] = b[0] ^ 8'h80;
    frame_case(b, 1, 0, 0, 0, 8'h01, 0, 12, "R7");
    // R9: reversed address bytes do not match
    frame_case(fr, 0, 0, 0, 0, 8'h01, 0, 12, "R9");
    // R9: frame shorter than the address never matches
    frame_case(fs, 1, 0, 0, 0, 8'h01, 0, 5, "R9");
    // R4: start strobes during the append are dropped
    frame_case(fm, 0, 0, 0, 3, 8'h02, 1, 14, "R4");
    // R11: controls flipped after the start byte have no effect
    frame_case(g, 1, 0, 1, 0, 8'h01, 0, 14, "R11");
    // R11: stray byte outside a frame
    cap_len = 0;
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1; in_data = 8'h77;
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    repeat (4) @(negedge clk);
    chk(cap_len == 0, "R11", "stray byte looped", cap_len, 0);
    chk(rx_status == 8'h01, "R10", "status held", 32'(rx_status), 32'h01);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    summary();
  end

endmodule